// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block is a watchdog that counts ticks from a free-running slow oscillator. That oscillator is separate from the processor clock. The tick arrives as a one-cycle enable. Because only the tick advances the count, the watchdog keeps timing while the processor's own clock is gated off during sleep. A base counter wraps every `BASE_TICKS` ticks. An optional postscaler then counts those wraps, with a power-of-two ratio from 1:1 up to 1:128 chosen by software.

Firmware holds the watchdog off by pulsing a kick input. Entering sleep pulses a sleep-command input. Either pulse restarts the whole timeout from zero and sets a time-out status flag. When the timeout runs out, the block acts according to the sleep state:

- While the processor runs, the block requests a device reset.
- While the processor sleeps, the block only requests a wake-up.

In both cases the status flag drops, which lets firmware tell a watchdog event apart from a power-up. A configuration enable that is held low turns the watchdog off completely.

All pins are plain control and status levels or pulses. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `wdog_postscaled_timer`

## Requirements
- R1: The base counter advances only in cycles where `tick_i` is 1. A timeout occurs on the tick that completes `BASE_TICKS` × ratio ticks counted from the last restart. The resulting request is visible one clock after that tick.
- R2: When `ps_to_wd_i` is 1, the ratio is 2^`ps_sel_i` (code 3'b000 gives 1:1 and code 3'b111 gives 1:128). When `ps_to_wd_i` is 0, the ratio is 1:1 whatever `ps_sel_i` holds.
- R3: A `kick_i` pulse sets both the base count and the postscaler count to zero. It also sets `to_flag_o` to 1 on the next clock. It takes priority over a tick in the same cycle.
- R4: A `sleep_cmd_i` pulse has exactly the same effect as `kick_i`.
- R5: A timeout while `sleeping_i` is 0 gives a `rst_req_o` pulse exactly one clock long, and `wake_req_o` stays 0.
- R6: A timeout while `sleeping_i` is 1 gives a `wake_req_o` pulse exactly one clock long, and `rst_req_o` stays 0.
- R7: `to_flag_o` is 1 after reset. It goes to 0 in the same clock as a timeout request and stays 0 until a kick or sleep-command pulse.
- R8: While `wd_enable_i` is 0, no counting happens and neither request is raised. Both counts are held at zero, so re-enabling times a full period.
- R9: A change of `ps_sel_i` or `ps_to_wd_i` clears the postscaler count, and the base count continues. The clear wins over a postscaler advance in the same cycle.
- R10: After a timeout, counting restarts from zero, so the next timeout follows a full period later if nothing restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Power-up reset, active low |
| tick_i | input | 1 | One-cycle tick from the slow free-running oscillator |
| wd_enable_i | input | 1 | Configuration enable; 0 disables the watchdog |
| kick_i | input | 1 | Watchdog restart pulse |
| sleep_cmd_i | input | 1 | Sleep-entry pulse; also restarts the watchdog |
| ps_to_wd_i | input | 1 | 1 = postscaler assigned to the watchdog |
| ps_sel_i | input | 3 | Postscaler ratio code, ratio 2^code |
| sleeping_i | input | 1 | 1 while the processor is asleep |
| rst_req_o | output | 1 | Device-reset request pulse |
| wake_req_o | output | 1 | Wake-up request pulse |
| to_flag_o | output | 1 | Time-out status; 0 after a timeout |

## Verification
The timeout length is measured for ratio codes 0, 3 and 7 with the postscaler assigned, and for code 7 with it unassigned. These runs tell a correct power-of-two decode apart from an off-by-one or an ignored assign bit. Further runs do the following:

- Stop the tick, disable the block, or restart it midway with either pulse. Each of these must lengthen the measured period exactly as the requirements predict.
- Change the ratio after one base wrap. This separates a postscaler that clears from one that keeps a stale partial count.
- Repeat the timeout asleep and awake, which separates the reset path from the wake path.

A behavioural model compares all three outputs on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WD_EV_NONE  = 2'd0,
    WD_EV_RESET = 2'd1,
    WD_EV_WAKE  = 2'd2
  } wd_evt_e;

endpackage

// File: rtl/wdog_base_ctr.sv
module wdog_base_ctr #(
  parameter int unsigned BASE_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic wrap_o
);

  localparam int unsigned CW = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = run_i & tick_i & ~clear_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || !run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= wrap_o ? '0 : cnt_q + CW'(1);
    end
  end

  // R1: count never passes the last base value
  a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R1: without a tick the count holds
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i && !tick_i) |=> $stable(cnt_q));

  // R8: disabled watchdog keeps the count at zero
  a_r8_held_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_postscaler.sv
module wdog_postscaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic             wrap_i,
  input  logic             assign_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);

  localparam int unsigned CODES = 1 << SEL_W;
  localparam int unsigned PW    = CODES - 1;

  logic [PW-1:0]    lim_tab [CODES];
  logic [PW-1:0]    lim;
  logic [PW-1:0]    cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             asg_q;
  logic             cfg_chg;

  for (genvar k = 0; k < CODES; k++) begin : g_lim
    assign lim_tab[k] = PW'((1 << k) - 1);
  end

  assign lim      = assign_i ? lim_tab[sel_i] : '0;
  assign cfg_chg  = (sel_i != sel_q) | (assign_i != asg_q);
  assign expire_o = wrap_i & ~cfg_chg & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      asg_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      asg_q <= assign_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || !run_i || cfg_chg) begin
      cnt_q <= '0;
    end else if (wrap_i) begin
      cnt_q <= expire_o ? '0 : cnt_q + PW'(1);
    end
  end

  // R9: a new ratio code leaves no stale partial count
  a_r9_sel_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i && (sel_i != $past(sel_i))) |=> (cnt_q == '0));

  // R2: with a stable setting the count stays below the ratio
  a_r2_cnt_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_chg |-> (cnt_q <= lim));

endmodule

// File: rtl/wdog_event.sv
module wdog_event
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic expire_i,
  input  logic sleeping_i,
  output logic rst_req_o,
  output logic wake_req_o,
  output logic to_flag_o
);

  wd_evt_e evt_d;

  always_comb begin
    if (!expire_i)       evt_d = WD_EV_NONE;
    else if (sleeping_i) evt_d = WD_EV_WAKE;
    else                 evt_d = WD_EV_RESET;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o  <= 1'b0;
      wake_req_o <= 1'b0;
      to_flag_o  <= 1'b1;
    end else begin
      rst_req_o  <= (evt_d == WD_EV_RESET);
      wake_req_o <= (evt_d == WD_EV_WAKE);
      if (clear_i)       to_flag_o <= 1'b1;
      else if (expire_i) to_flag_o <= 1'b0;
    end
  end

  // R5: reset request lasts one clock
  a_r5_rst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R6: wake request lasts one clock, never together with reset
  a_r6_wake_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |=> !wake_req_o);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && wake_req_o));

  // R7: a request always comes with the flag low
  a_r7_flag_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || wake_req_o) |-> !to_flag_o);

  // R3: restart raises the flag on the next clock
  a_r3_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> to_flag_o);

endmodule

// File: rtl/wdog_postscaled_timer.sv
module wdog_postscaled_timer #(
  parameter int unsigned BASE_TICKS = 20,
  parameter int unsigned SEL_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wd_enable_i,
  input  logic             kick_i,
  input  logic             sleep_cmd_i,
  input  logic             ps_to_wd_i,
  input  logic [SEL_W-1:0] ps_sel_i,
  input  logic             sleeping_i,
  output logic             rst_req_o,
  output logic             wake_req_o,
  output logic             to_flag_o
);

  logic restart;
  logic base_wrap;
  logic expire;

  assign restart = kick_i | sleep_cmd_i;

  wdog_base_ctr #(.BASE_TICKS(BASE_TICKS)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (wd_enable_i),
    .clear_i (restart),
    .tick_i  (tick_i),
    .wrap_o  (base_wrap)
  );

  wdog_postscaler #(.SEL_W(SEL_W)) u_ps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (wd_enable_i),
    .clear_i  (restart),
    .wrap_i   (base_wrap),
    .assign_i (ps_to_wd_i),
    .sel_i    (ps_sel_i),
    .expire_o (expire)
  );

  wdog_event u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (restart),
    .expire_i   (expire),
    .sleeping_i (sleeping_i),
    .rst_req_o  (rst_req_o),
    .wake_req_o (wake_req_o),
    .to_flag_o  (to_flag_o)
  );

  // R8: a disabled watchdog raises no request
  a_r8_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_enable_i |=> !(rst_req_o || wake_req_o));

  // R4: sleep command restarts like a kick
  a_r4_sleep_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_cmd_i |=> (to_flag_o && !rst_req_o && !wake_req_o));

endmodule

// File: tb/wdog_postscaled_timer_tb.sv
module wdog_postscaled_timer_tb;

  localparam int BASE = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1, en = 1'b1, kick = 1'b0, slp = 1'b0;
  logic       asg = 1'b0, sleeping = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       rst_req, wake_req, to_flag;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  // model state
  int  m_base, m_ps, m_psel, m_pasg;
  bit  m_rst, m_wake, m_to;

  always #4 clk = ~clk;

  wdog_postscaled_timer #(.BASE_TICKS(BASE), .SEL_W(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wd_enable_i(en),
    .kick_i(kick), .sleep_cmd_i(slp), .ps_to_wd_i(asg), .ps_sel_i(sel),
    .sleeping_i(sleeping), .rst_req_o(rst_req), .wake_req_o(wake_req),
    .to_flag_o(to_flag)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_ps = 0; m_psel = 0; m_pasg = 0;
      m_rst = 0; m_wake = 0; m_to = 1;
    end else begin
      bit wrap, fire, chg;
      int ratio;
      wrap = 0; fire = 0;
      m_rst = 0; m_wake = 0;
      chg = (int'(sel) != m_psel) || (int'(asg) != m_pasg);
      ratio = asg ? (1 << sel) : 1;
      if (kick || slp) begin
        m_base = 0; m_ps = 0; m_to = 1;
      end else if (!en) begin
        m_base = 0; m_ps = 0;
      end else begin
        if (tick) begin
          if (m_base == BASE - 1) begin m_base = 0; wrap = 1; end
          else m_base++;
        end
        if (chg) m_ps = 0;
        else if (wrap) begin
          if (m_ps == ratio - 1) begin m_ps = 0; fire = 1; end
          else m_ps++;
        end
        if (fire) begin
          m_to = 0;
          if (sleeping) m_wake = 1; else m_rst = 1;
        end
      end
      m_psel = int'(sel); m_pasg = int'(asg);
    end
  end

  // per-clock comparison with the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      tests++;
      if (rst_req !== m_rst) begin
        fails++;
        $display("FAIL R5 rst_req actual %0b expected %0b at %0t", rst_req, m_rst, $time);
      end else if (wake_req !== m_wake) begin
        fails++;
        $display("FAIL R6 wake_req actual %0b expected %0b at %0t", wake_req, m_wake, $time);
      end else if (to_flag !== m_to) begin
        fails++;
        $display("FAIL R7 to_flag actual %0b expected %0b at %0t", to_flag, m_to, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input bit use_sleep);
    @(negedge clk);
    if (use_sleep) slp = 1'b1; else kick = 1'b1;
    @(negedge clk);
    slp = 1'b0; kick = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(rst_req || wake_req) && n < 5000);
  endtask

  task automatic quiet(input int len, output int evs);
    evs = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (rst_req || wake_req) evs++;
    end
  endtask

  initial begin
    int n, evs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset flag", int'(to_flag), 1);
    check("R5 reset rst_req", int'(rst_req), 0);

    // R1 R2 ratio codes with the postscaler assigned
    asg = 1'b1;
    sel = 3'd0; restart(0); measure(n); check("R2 code0 period", n, BASE);
    check("R5 rst on awake timeout", int'(rst_req), 1);
    check("R6 no wake while awake", int'(wake_req), 0);
    @(negedge clk);
    check("R5 single pulse", int'(rst_req), 0);
    sel = 3'd3; restart(0); measure(n); check("R2 code3 period", n, BASE * 8);
    sel = 3'd7; restart(0); measure(n); check("R1 code7 period", n, BASE * 128);
    asg = 1'b0; restart(0); measure(n); check("R2 unassigned period", n, BASE);

    // R10 back-to-back periods without restart
    asg = 1'b1; sel = 3'd2; restart(0); measure(n);
    measure(n); check("R10 next period", n, BASE * 4);

    // R7 flag held low until restart
    repeat (5) @(negedge clk);
    check("R7 flag stays low", int'(to_flag), 0);
    restart(0);
    check("R7 flag set by kick", int'(to_flag), 1);

    // R3 kick midway restarts a full period
    sel = 3'd1; restart(0);
    repeat (BASE + 7) @(negedge clk);
    restart(0); measure(n); check("R3 kick midway", n, BASE * 2);

    // R4 sleep command midway, R6 timeout while asleep
    sleeping = 1'b1;
    repeat (BASE + 5) @(negedge clk);
    restart(1); measure(n); check("R4 sleep restart period", n, BASE * 2);
    check("R6 wake on asleep timeout", int'(wake_req), 1);
    check("R6 no reset while asleep", int'(rst_req), 0);
    @(negedge clk);
    check("R6 single wake pulse", int'(wake_req), 0);
    sleeping = 1'b0;

    // R1 no ticks, no progress
    restart(0); tick = 1'b0;
    quiet(3000, evs); check("R1 no tick no event", evs, 0);
    tick = 1'b1; measure(n); check("R1 period after tick gap", n, BASE * 2);

    // R8 disabled
    restart(0);
    repeat (BASE + 3) @(negedge clk);
    en = 1'b0;
    quiet(3000, evs); check("R8 disabled no event", evs, 0);
    en = 1'b1; measure(n); check("R8 fresh period on enable", n, BASE * 2);

    // R9 ratio change clears the postscaler
    sel = 3'd1; restart(0);
    repeat (BASE + 3) @(negedge clk);
    sel = 3'd2;
    measure(n); check("R9 stale count cleared", n, 4 * BASE - 3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual %0d expected below 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule